// File: doc/BRIEF.md
# I2C Slave Controller with Clock Stretching

This block is the target side of a two-wire bus. It watches the clock and data lines after a synchroniser and reacts to start and stop conditions. It compares the first byte after a start against a 7-bit station address. When the address matches, it moves data bytes between the bus and the host. A single byte register faces the host on each side.

Open-drain behaviour is modelled with two pull-low enables, `scl_oe` and `sda_oe`. The block drives a line low when its enable is 1 and releases it when the enable is 0.

Received bytes leave on a valid/ready stream (`rx_*`). The byte is presented with `rx_valid` high and held until a cycle in which `rx_ready` is also high. Bytes for a read come in on a second valid/ready stream (`tx_*`). `tx_ready` is high only while the slave is holding the bus clock waiting for a byte. The byte is taken in the cycle where `tx_valid` and `tx_ready` are both high.

Back-pressure on either stream reaches the bus master as clock stretching. On the receive side this stretching can be switched off, in which case a late host loses bytes and sees an overrun event. Four single-cycle event pulses report bus activity to the host:
- a start or stop condition,
- a completed data byte,
- an acknowledge bit,
- an overrun.

Top module: `i2c_stretch_slave`

## Requirements
- R1: A falling edge of SDA while SCL is high is a start condition. A rising edge of SDA while SCL is high is a stop condition. Each one gives a single-cycle pulse on `ev_startstop`. After a stop, both `scl_oe` and `sda_oe` are 0.
- R2: After a start, the first 8 bits clocked in form the address byte, most significant bit first on the wire. Bits 7..1 are compared with `own_addr` and bit 0 is the direction (1 = read). On a match, the slave pulls SDA low for the ninth clock.
- R3: On an address mismatch, the slave leaves SDA released for the ninth clock, so the master sees NAK = 1. It then ignores all clocks and data until the next start. No byte is delivered and no `ev_data` pulse is raised.
- R4: In a write transfer, each data byte is delivered on `rx_data` with `rx_valid` after its eighth clock. In the ninth clock, the slave pulls SDA low when `nak_sel` = 0 and leaves it released when `nak_sel` = 1.
- R5: When `lsb_first` = 0, the first data bit on the wire is bit 7. When `lsb_first` = 1, the first data bit on the wire is bit 0. This applies to data bytes in both directions; the address byte is always most significant bit first.
- R6: While `rx_valid` = 1 and `rx_ready` = 0, `rx_valid` stays high and `rx_data` does not change.
- R7: With `stretch_en` = 1, when the acknowledge clock that comes before a write data byte falls while `rx_valid` is high, the slave holds SCL low (`scl_oe` = 1). It keeps SCL low until the receive byte has been taken, and then releases it.
- R8: With `stretch_en` = 0, if a write byte completes while `rx_valid` = 1 and `rx_ready` = 0, the slave raises one `ev_overrun` pulse. The new byte is dropped and `rx_data` keeps the unread byte.
- R9: After acknowledging a read address, and after each master ACK in a read, the slave holds SCL low with `tx_ready` = 1 until `tx_valid` = 1. It then loads `tx_data`, releases SCL and drives the byte's bits on SDA.
- R10: A master NAK (SDA high on the ninth clock of a read byte) ends the read. The slave releases SDA and takes no part in the bus until the next start; further clocks read back as all ones.
- R11: `ev_data` pulses once for each completed data byte in either direction, but never for the address byte. `ev_ack` pulses once for each ninth clock of an addressed transfer. `ev_startstop`, `ev_data` and `ev_ack` never pulse in the same cycle.
- R12: A start condition seen at any point, including in the middle of a byte, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | 1 = pull bus clock low (stretch) |
| sda_oe | output | 1 | 1 = pull bus data low |
| own_addr | input | 7 | Station address |
| lsb_first | input | 1 | Data bit order: 0 = bit 7 first, 1 = bit 0 first |
| nak_sel | input | 1 | Acknowledge for written bytes: 0 = ACK, 1 = NAK |
| stretch_en | input | 1 | Stretch SCL while the receive byte is unread |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte present |
| rx_ready | input | 1 | Host takes the received byte |
| tx_data | input | 8 | Byte to send in a read |
| tx_valid | input | 1 | Host offers a byte to send |
| tx_ready | output | 1 | Slave waits for a byte, clock held |
| ev_startstop | output | 1 | Pulse on start or stop |
| ev_data | output | 1 | Pulse on completed data byte |
| ev_ack | output | 1 | Pulse on acknowledge clock |
| ev_overrun | output | 1 | Pulse when a written byte is lost |

## Verification
The bench targets the points where a slave most often goes wrong. A wrong address must be NAKed and all further traffic ignored; a faulty design would keep acknowledging bytes, or deliver bytes that were never meant for it. It checks the acknowledge-phase stretch in both directions; a design that released SCL too early would let the master clock a stale byte or stale bits. It checks reversed bit order on both paths, and overrun with stretching disabled, where a design that overwrote the buffer would lose the older byte. Last, it sends a repeated start in the middle of an address byte; a design that kept counting bits would fail to acknowledge the new address.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout,
  output logic [LINES-1:0] dprev
);
  logic [LINES-1:0] pipe [0:STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout  = pipe[STAGES-1];
  assign dprev = pipe[STAGES];
endmodule

// File: rtl/i2cs_rxbuf.sv
module i2cs_rxbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         rd_ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      ovr   <= 1'b0;
    end else begin
      ovr <= push && valid && !rd_ready;
      if (push && (!valid || rd_ready)) begin
        data  <= din;
        valid <= 1'b1;
      end else if (rd_ready) begin
        valid <= 1'b0;
      end
    end
  end

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rd_ready) |=> (valid && $stable(data)));

  // R8
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> (valid && $stable(data)));
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              lsb_first,
  input  logic              nak_sel,
  input  logic              stretch_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              ev_startstop,
  output logic              ev_data,
  output logic              ev_ack,
  output logic              ev_overrun
);
  import i2cs_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] PENULT = CNT_W'(DATA_W - 1);

  logic [1:0] ln_now, ln_prev;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2cs_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({scl_i, sda_i}),
    .dout  (ln_now),
    .dprev (ln_prev)
  );

  assign scl_s     = ln_now[1];
  assign sda_s     = ln_now[0];
  assign scl_p     = ln_prev[1];
  assign sda_p     = ln_prev[0];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  i2cs_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr, txsr, rx_next;
  logic              hold, rw, nak_q, mnak;
  logic              push, addr_hit, tx_bit;

  assign rx_next  = (lsb_first && state == ST_WDATA) ? {sda_s, sr[DATA_W-1:1]}
                                                     : {sr[DATA_W-2:0], sda_s};
  assign addr_hit = (sr[DATA_W-1:DATA_W-ADDR_W] == own_addr);
  assign tx_bit   = lsb_first ? txsr[0] : txsr[DATA_W-1];
  assign tx_ready = (state == ST_RDATA) && hold;
  assign push     = !hold && (state == ST_WDATA) && scl_rise && (cnt == PENULT);

  i2cs_rxbuf #(.W(DATA_W)) u_rxbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .din      (rx_next),
    .rd_ready (rx_ready),
    .valid    (rx_valid),
    .data     (rx_data),
    .ovr      (ev_overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; sr <= '0; txsr <= '0;
      hold <= 1'b0; rw <= 1'b0; nak_q <= 1'b0; mnak <= 1'b1;
      ev_startstop <= 1'b0; ev_data <= 1'b0; ev_ack <= 1'b0;
    end else begin
      ev_startstop <= 1'b0;
      ev_data      <= 1'b0;
      ev_ack       <= 1'b0;
      if (start_det) begin
        ev_startstop <= 1'b1;
        state <= ST_ADDR;
        cnt   <= '0;
        hold  <= 1'b0;
      end else if (stop_det) begin
        ev_startstop <= 1'b1;
        state <= ST_IDLE;
        hold  <= 1'b0;
      end else if (hold) begin
        if (state == ST_RDATA) begin
          if (tx_valid) begin
            txsr <= tx_data;
            hold <= 1'b0;
          end
        end else if (!rx_valid || !stretch_en) begin
          hold <= 1'b0;
        end
      end else begin
        case (state)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && cnt != LAST) begin
              sr  <= rx_next;
              cnt <= cnt + 1'b1;
              if (state == ST_WDATA && cnt == PENULT) ev_data <= 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  state <= ST_AACK;
                  rw    <= sr[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state <= ST_WACK;
                nak_q <= nak_sel;
              end
            end
          end
          ST_AACK, ST_WACK, ST_RACK: begin
            if (scl_rise) begin
              ev_ack <= 1'b1;
              mnak   <= sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (state == ST_RACK && mnak) begin
                state <= ST_IDLE;
              end else if (rw) begin
                state <= ST_RDATA;
                hold  <= 1'b1;
              end else begin
                state <= ST_WDATA;
                hold  <= stretch_en && rx_valid && !rx_ready;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise && cnt != LAST) begin
              cnt <= cnt + 1'b1;
              if (cnt == PENULT) ev_data <= 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) state <= ST_RACK;
              else txsr <= lsb_first ? (txsr >> 1) : (txsr << 1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_oe = hold;
  assign sda_oe = (state == ST_AACK) ||
                  (state == ST_WACK && !nak_q) ||
                  (state == ST_RDATA && !hold && !tx_bit);

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !scl_oe));

  // R9
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !scl_oe);

  // R11
  ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_startstop, ev_data, ev_ack}));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !tx_ready && stretch_en && rx_valid) |=> scl_oe);
endmodule

// File: tb/sim_i2c_stretch_slave.sv
module sim_i2c_stretch_slave;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic lsb_first = 1'b0, nak_sel = 1'b0, stretch_en = 1'b1;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;
  logic ev_startstop, ev_data, ev_ack, ev_overrun;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_stretch_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(ADDR),
    .lsb_first(lsb_first), .nak_sel(nak_sel), .stretch_en(stretch_en),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ev_startstop(ev_startstop), .ev_data(ev_data), .ev_ack(ev_ack),
    .ev_overrun(ev_overrun)
  );

  int n_ss = 0, n_dat = 0, n_ack = 0, n_ovr = 0;
  always @(posedge clk) begin
    if (ev_startstop) n_ss++;
    if (ev_data) n_dat++;
    if (ev_ack) n_ack++;
    if (ev_overrun) n_ovr++;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_high();
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_line);
    qwait();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_high();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_high();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl_high();
    scl_m = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl_high();
    b = sda_line;
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(mack);
  endtask

  task automatic pop_rx(input logic [7:0] exp, input string tag);
    chk(rx_valid === 1'b1, tag, rx_valid, 1);
    chk(rx_data === exp, tag, rx_data, exp);
    rx_ready = 1'b1; @(negedge clk);
    rx_ready = 1'b0; repeat (3) @(negedge clk);
    chk(rx_valid === 1'b0, tag, rx_valid, 0);
  endtask

  task automatic provide_tx(input logic [7:0] d);
    repeat (30) @(negedge clk);
    chk(scl_oe === 1'b1 && tx_ready === 1'b1, "R9 hold for tx", {scl_oe, tx_ready}, 3);
    tx_data = d; tx_valid = 1'b1; @(negedge clk);
    tx_valid = 1'b0; @(negedge clk);
    chk(scl_oe === 1'b0, "R9 release after load", scl_oe, 0);
  endtask

  task automatic t_reset();
    chk(scl_oe === 1'b0 && sda_oe === 1'b0, "R1 reset lines released", {scl_oe, sda_oe}, 0);
    chk(rx_valid === 1'b0 && tx_ready === 1'b0, "R6 reset streams idle", {rx_valid, tx_ready}, 0);
  endtask

  task automatic t_write_msb();
    logic ack;
    int s0 = n_ss, d0 = n_dat, a0 = n_ack;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    chk(ack === 1'b0, "R2 address ack", ack, 0);
    send_byte(8'hA5, ack);
    chk(ack === 1'b0, "R4 data ack", ack, 0);
    chk(scl_oe === 1'b1, "R7 stretch while unread", scl_oe, 1);
    repeat (20) @(negedge clk);
    chk(rx_valid === 1'b1 && rx_data === 8'hA5, "R6 byte held", rx_data, 8'hA5);
    pop_rx(8'hA5, "R4 first byte");
    chk(scl_oe === 1'b0, "R7 release after read", scl_oe, 0);
    send_byte(8'h3C, ack);
    pop_rx(8'h3C, "R4 second byte");
    bus_stop();
    repeat (5) @(negedge clk);
    chk(n_ss - s0 == 2, "R1 start and stop events", n_ss - s0, 2);
    chk(n_dat - d0 == 2, "R11 data events", n_dat - d0, 2);
    chk(n_ack - a0 == 3, "R11 ack events", n_ack - a0, 3);
  endtask

  task automatic t_nak_sel();
    logic ack;
    nak_sel = 1'b1;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    chk(ack === 1'b0, "R2 address ack with nak_sel", ack, 0);
    send_byte(8'h11, ack);
    chk(ack === 1'b1, "R4 nak_sel gives NAK", ack, 1);
    pop_rx(8'h11, "R4 byte under NAK");
    bus_stop();
    nak_sel = 1'b0;
  endtask

  task automatic t_mismatch();
    logic ack;
    int d0 = n_dat;
    bus_start();
    send_byte({7'h2B, 1'b0}, ack);
    chk(ack === 1'b1, "R3 mismatch NAK", ack, 1);
    send_byte(8'h99, ack);
    chk(ack === 1'b1, "R3 data ignored NAK", ack, 1);
    chk(rx_valid === 1'b0, "R3 nothing delivered", rx_valid, 0);
    chk(n_dat == d0, "R3 no data event", n_dat - d0, 0);
    bus_stop();
  endtask

  task automatic t_lsb();
    logic ack;
    logic [7:0] b;
    lsb_first = 1'b1;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h12, ack);
    pop_rx(8'h48, "R5 lsb first write");
    bus_stop();
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    chk(ack === 1'b0, "R2 read address ack", ack, 0);
    fork
      recv_byte(b, 1'b1);
      provide_tx(8'h48);
    join
    chk(b === 8'h12, "R5 lsb first read", b, 8'h12);
    bus_stop();
    lsb_first = 1'b0;
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] b;
    int d0 = n_dat, a0 = n_ack;
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    chk(ack === 1'b0, "R2 read address ack", ack, 0);
    fork
      recv_byte(b, 1'b0);
      provide_tx(8'hC3);
    join
    chk(b === 8'hC3, "R9 first read byte", b, 8'hC3);
    fork
      recv_byte(b, 1'b1);
      provide_tx(8'h5A);
    join
    chk(b === 8'h5A, "R9 second read byte", b, 8'h5A);
    chk(sda_oe === 1'b0 && scl_oe === 1'b0 && tx_ready === 1'b0, "R10 released after NAK",
        {sda_oe, scl_oe, tx_ready}, 0);
    recv_byte(b, 1'b1);
    chk(b === 8'hFF, "R10 idle after NAK", b, 8'hFF);
    chk(n_dat - d0 == 2, "R11 read data events", n_dat - d0, 2);
    chk(n_ack - a0 == 3, "R11 read ack events", n_ack - a0, 3);
    bus_stop();
  endtask

  task automatic t_overrun();
    logic ack;
    int o0 = n_ovr;
    stretch_en = 1'b0;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h01, ack);
    chk(scl_oe === 1'b0, "R8 no stretch when disabled", scl_oe, 0);
    send_byte(8'h02, ack);
    chk(n_ovr - o0 == 1, "R8 overrun event", n_ovr - o0, 1);
    pop_rx(8'h01, "R8 old byte kept");
    bus_stop();
    stretch_en = 1'b1;
  endtask

  task automatic t_rstart();
    logic ack;
    int s0 = n_ss;
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    chk(ack === 1'b0, "R12 address after repeated start", ack, 0);
    send_byte(8'h77, ack);
    chk(ack === 1'b0, "R12 data ack", ack, 0);
    pop_rx(8'h77, "R12 byte after repeated start");
    bus_stop();
    repeat (5) @(negedge clk);
    chk(n_ss - s0 == 3, "R12 start events", n_ss - s0, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_msb();
    t_nak_sel();
    t_mismatch();
    t_lsb();
    t_read();
    t_overrun();
    t_rstart();
    repeat (10) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule